// File: doc/BRIEF.md
# Segment register load checker

This block rules on whether a selector, together with the descriptor attributes already fetched for it, may be placed into one of eight segment registers: the code, stack and four data registers, the local table register and the task register. The requester supplies the target register code, the 16-bit selector, the descriptor's system flag, type nibble, privilege level and present bit. It also supplies the current privilege level, a 64-bit mode flag and the byte limits of the global and local descriptor tables.

One cycle after a request is accepted, the block returns a verdict. The verdict is either acceptance or a single 3-bit fault class. When several checks fail, only the one of highest priority is reported. The response is held until the consumer takes it. The surrounding machinery fetches the descriptor, fills the hidden register part and handles gates.

Top module: `seg_load_check`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high at a clock edge, and the verdict appears with `rsp_valid` high after that edge. `req_ready` is high exactly when no verdict is held or `rsp_ready` is high. A held verdict stays unchanged while `rsp_ready` is low. `rsp_valid` falls after an edge with `rsp_ready` high and no new request.
- R2: A selector whose index (bits 15:3) and table bit (bit 2) are all zero is null. A null selector yields code 1 for the code register (target 0) and the task register (target 7). It also yields code 1 for the stack register (target 1), except in 64-bit mode with current level below 3. Every other null case is accepted with code 0, and no other check applies to it.
- R3: Bit 2 of the selector picks the table: 0 means the global table, 1 means the local table. The load yields code 2 when index*8+7 exceeds that table's limit. For targets 6 and 7 in 64-bit mode, the bound is index*8+15.
- R4: The code register (target 0) needs a system flag of 1 and type bit 3 set. Otherwise it yields code 3.
- R5: The stack register (target 1) needs a system flag of 1, type bit 3 clear and type bit 1 set (a writable data segment). Otherwise it yields code 3.
- R6: The data registers (targets 2 to 5) yield code 3 for a system descriptor (flag 0). They also yield code 3 for a code type (bit 3 set) whose readable bit 1 is clear.
- R7: The local table register (target 6) needs a system descriptor of type 2. The task register (target 7) needs a system descriptor of type 9, or of type 1 outside 64-bit mode. Otherwise code 3.
- R8: The effective level is the larger of the current level and the selector's requested level (bits 1:0). A data register load of a data segment or of a non-conforming code segment (type bit 2 clear) yields code 4 when the effective level exceeds the descriptor level. Conforming code is exempt from this check.
- R9: A stack register load yields code 4 unless the requested level and the descriptor level both equal the current level.
- R10: A code register load yields code 4 under either of two conditions. For a conforming segment (type bit 2 set), it faults when the current level is below the descriptor level. For a non-conforming segment, it faults when the current level differs from the descriptor level or the requested level exceeds the current level.
- R11: A clear present bit yields code 6 for the stack register and code 5 for every other target.
- R12: Checks rank null, then table limit, then type, then privilege, then present, and only the first failure is reported. `rsp_ok` is high exactly when the held code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_tgt | input | 3 | Target register: 0 code, 1 stack, 2..5 data, 6 local table, 7 task |
| req_sel | input | 16 | Selector: index, table bit, requested level |
| req_s | input | 1 | Descriptor flag: 1 code/data, 0 system |
| req_type | input | 4 | Descriptor type nibble |
| req_dpl | input | 2 | Descriptor privilege level |
| req_p | input | 1 | Descriptor present bit |
| req_cpl | input | 2 | Current privilege level |
| req_mode64 | input | 1 | 1 in 64-bit mode |
| gdt_lim | input | 16 | Byte limit of the global table |
| ldt_lim | input | 16 | Byte limit of the local table |
| rsp_valid | output | 1 | Verdict held |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_ok | output | 1 | Load accepted |
| rsp_fault | output | 3 | Fault class, 0 when accepted |

## Verification
The main sweep runs through every combination of target, mode, system flag, type nibble, descriptor level, present bit, current level and requested level on a selector that is well inside the table. This separates the type, privilege and present rules per target and shows which check wins when several fail. A second sweep walks the selector index across both table limits with both table bits and both modes, which exposes off-by-one bounds and the wider 16-byte entries of the system targets. A third sweep covers null selectors and the local-table index-0 selector under every target and level, and a stall sequence shows that the verdict is held and new requests are refused while the consumer is not ready.

// File: rtl/seg_chk_pkg.sv
// Shared codes for the segment register load checker.
// Assumes the target and fault encodings listed in the brief.
package seg_chk_pkg;
    typedef enum logic [2:0] {
        TGT_CS   = 3'd0,
        TGT_SS   = 3'd1,
        TGT_DS   = 3'd2,
        TGT_ES   = 3'd3,
        TGT_FS   = 3'd4,
        TGT_GS   = 3'd5,
        TGT_LDTR = 3'd6,
        TGT_TR   = 3'd7
    } seg_tgt_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_LIMIT  = 3'd2,
        FLT_TYPE   = 3'd3,
        FLT_PRIV   = 3'd4,
        FLT_ABSENT = 3'd5,
        FLT_STACK  = 3'd6
    } seg_flt_e;

    localparam logic [3:0] SYS_LDT      = 4'h2;
    localparam logic [3:0] SYS_TSS16    = 4'h1;
    localparam logic [3:0] SYS_TSS32    = 4'h9;
endpackage

// File: rtl/seg_sel_decode.sv
// Selector decode: null detection, effective level and table limit test.
// Assumes index in the upper SEL_W-3 bits, table bit at 2, requested level
// in bits 1:0; each entry is 8 bytes, 16 bytes for system targets in 64-bit mode.
module seg_sel_decode
    import seg_chk_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seg_tgt_e         tgt,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       cpl,
    input  logic             mode64,
    input  logic [LIM_W-1:0] gdt_lim,
    input  logic [LIM_W-1:0] ldt_lim,
    output logic             is_null,
    output logic             null_ok,
    output logic [1:0]       rpl,
    output logic [1:0]       epl,
    output logic             lim_fail
);
    localparam int OFF_W  = SEL_W + 1;
    localparam int CMP_W  = (OFF_W > LIM_W) ? OFF_W : LIM_W;
    localparam int N_TBL  = 2;

    logic             wide;
    logic [OFF_W-1:0] end_off;
    logic [LIM_W-1:0] lim_tbl [N_TBL];
    logic [N_TBL-1:0] over;

    // Requested and effective privilege from the selector and current level.
    always_comb begin
        rpl = sel[1:0];
        epl = (cpl > sel[1:0]) ? cpl : sel[1:0];
    end

    // Null selector and whether the target tolerates it.
    always_comb begin
        is_null = (sel[SEL_W-1:2] == '0);
        unique case (tgt)
            TGT_CS, TGT_TR: null_ok = 1'b0;
            TGT_SS:         null_ok = mode64 && (cpl != 2'd3);
            default:        null_ok = 1'b1;
        endcase
    end

    // Last byte of the referenced entry.
    always_comb begin
        wide    = mode64 && (tgt == TGT_LDTR || tgt == TGT_TR);
        end_off = {1'b0, sel[SEL_W-1:3], 3'b000} + OFF_W'(wide ? 4'd15 : 4'd7);
    end

    assign lim_tbl[0] = gdt_lim;
    assign lim_tbl[1] = ldt_lim;

    // One bound comparator per descriptor table.
    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        assign over[t] = CMP_W'(end_off) > CMP_W'(lim_tbl[t]);
    end

    assign lim_fail = over[sel[2]];

    AST_EPL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (epl >= cpl) && (epl >= rpl)); // R8
    AST_NULL_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        is_null |-> !lim_fail || (gdt_lim < LIM_W'(7))); // R3
endmodule

// File: rtl/seg_rule_eval.sv
// Per-target type and privilege rules for a non-null selector.
// Assumes type bit 3 = code, bit 2 = conforming/expand-down, bit 1 = readable/writable.
module seg_rule_eval
    import seg_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seg_tgt_e   tgt,
    input  logic       s,
    input  logic [3:0] typ,
    input  logic [1:0] dpl,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  logic [1:0] epl,
    input  logic       mode64,
    output logic       type_fail,
    output logic       priv_fail
);
    logic is_code;
    logic rw_bit;
    logic conf_bit;

    // Field views of the type nibble.
    always_comb begin
        is_code  = s && typ[3];
        rw_bit   = typ[1];
        conf_bit = typ[2];
    end

    // Type acceptance by target register.
    always_comb begin
        unique case (tgt)
            TGT_CS:   type_fail = !is_code;
            TGT_SS:   type_fail = !(s && !typ[3] && rw_bit);
            TGT_LDTR: type_fail = !(!s && typ == SYS_LDT);
            TGT_TR:   type_fail = !(!s && (typ == SYS_TSS32 ||
                                           (!mode64 && typ == SYS_TSS16)));
            default:  type_fail = !s || (typ[3] && !rw_bit);
        endcase
    end

    // Privilege acceptance by target register.
    always_comb begin
        unique case (tgt)
            TGT_CS:   priv_fail = conf_bit ? (cpl < dpl)
                                           : ((cpl != dpl) || (rpl > cpl));
            TGT_SS:   priv_fail = (rpl != cpl) || (dpl != cpl);
            TGT_LDTR,
            TGT_TR:   priv_fail = 1'b0;
            default:  priv_fail = (is_code && conf_bit) ? 1'b0 : (epl > dpl);
        endcase
    end

    AST_CS_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_CS) && !type_fail |-> s && typ[3]); // R4
    AST_SS_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_SS) && !type_fail |-> s && !typ[3] && typ[1]); // R5
    AST_SYS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_LDTR || tgt == TGT_TR) && !type_fail |-> !s); // R7
    AST_SS_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_SS) && !priv_fail |-> (dpl == cpl) && (epl == cpl)); // R9
endmodule

// File: rtl/seg_fault_prio.sv
// Picks the single reported fault from the individual check results.
// Assumes the order null, limit, type, privilege, present.
module seg_fault_prio
    import seg_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     is_null,
    input  logic     null_ok,
    input  logic     lim_fail,
    input  logic     type_fail,
    input  logic     priv_fail,
    input  logic     present,
    input  logic     is_stack,
    output seg_flt_e fault
);
    // First failing check wins.
    always_comb begin
        if (is_null)        fault = null_ok ? FLT_NONE : FLT_NULL;
        else if (lim_fail)  fault = FLT_LIMIT;
        else if (type_fail) fault = FLT_TYPE;
        else if (priv_fail) fault = FLT_PRIV;
        else if (!present)  fault = is_stack ? FLT_STACK : FLT_ABSENT;
        else                fault = FLT_NONE;
    end

    AST_NULL_SHORTCUT: assert property (@(posedge clk) disable iff (!rst_n)
        is_null |-> (fault == FLT_NONE) || (fault == FLT_NULL)); // R2
    AST_STACK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == FLT_STACK) |-> is_stack && !present); // R11
    AST_ACCEPT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (fault == FLT_NONE) && !is_null |-> !lim_fail && !type_fail && !priv_fail && present); // R12
endmodule

// File: rtl/seg_load_check.sv
// Segment register load checker top: combines selector decode, rule
// evaluation and fault priority, and registers the verdict behind a
// valid/ready pair. Assumes the descriptor fields are stable with req_valid.
module seg_load_check
    import seg_chk_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_tgt,
    input  logic [SEL_W-1:0] req_sel,
    input  logic             req_s,
    input  logic [3:0]       req_type,
    input  logic [1:0]       req_dpl,
    input  logic             req_p,
    input  logic [1:0]       req_cpl,
    input  logic             req_mode64,
    input  logic [LIM_W-1:0] gdt_lim,
    input  logic [LIM_W-1:0] ldt_lim,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_ok,
    output logic [2:0]       rsp_fault
);
    seg_tgt_e tgt;
    seg_flt_e fault_c;
    logic     is_null, null_ok, lim_fail, type_fail, priv_fail;
    logic [1:0] rpl, epl;
    logic     take;

    assign tgt  = seg_tgt_e'(req_tgt);
    assign take = req_valid && req_ready;

    seg_sel_decode #(.SEL_W(SEL_W), .LIM_W(LIM_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .sel(req_sel), .cpl(req_cpl),
        .mode64(req_mode64), .gdt_lim(gdt_lim), .ldt_lim(ldt_lim),
        .is_null(is_null), .null_ok(null_ok), .rpl(rpl), .epl(epl),
        .lim_fail(lim_fail)
    );

    seg_rule_eval u_rule (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .s(req_s), .typ(req_type),
        .dpl(req_dpl), .cpl(req_cpl), .rpl(rpl), .epl(epl),
        .mode64(req_mode64), .type_fail(type_fail), .priv_fail(priv_fail)
    );

    seg_fault_prio u_prio (
        .clk(clk), .rst_n(rst_n), .is_null(is_null), .null_ok(null_ok),
        .lim_fail(lim_fail), .type_fail(type_fail), .priv_fail(priv_fail),
        .present(req_p), .is_stack(tgt == TGT_SS), .fault(fault_c)
    );

    // Ready when nothing is held or the held verdict leaves this cycle.
    assign req_ready = !rsp_valid || rsp_ready;

    // Verdict valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         rsp_valid <= 1'b0;
        else if (take)      rsp_valid <= 1'b1;
        else if (rsp_ready) rsp_valid <= 1'b0;
    end

    // Verdict code, captured on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)    rsp_fault <= 3'd0;
        else if (take) rsp_fault <= fault_c;
    end

    assign rsp_ok = (rsp_fault == FLT_NONE);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rsp_valid); // R1
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault)); // R1
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !take && rsp_ready |=> !rsp_valid); // R1
endmodule

// File: tb/tb_seg_load_check.sv
module tb_seg_load_check;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_tgt = 3'd0;
    logic [15:0] req_sel = 16'd0;
    logic        req_s = 1'b0;
    logic [3:0]  req_type = 4'd0;
    logic [1:0]  req_dpl = 2'd0;
    logic        req_p = 1'b0;
    logic [1:0]  req_cpl = 2'd0;
    logic        req_mode64 = 1'b0;
    logic [15:0] gdt_lim = 16'h00FF;
    logic [15:0] ldt_lim = 16'h004F;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_ok;
    logic [2:0]  rsp_fault;

    int n_vec = 0;
    int n_bad = 0;
    logic       pend = 1'b0;
    logic [2:0] exp_q = 3'd0;
    logic [2:0] exp_tgt_q = 3'd0;
    logic       done = 1'b0;

    seg_load_check dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_tgt(req_tgt), .req_sel(req_sel), .req_s(req_s), .req_type(req_type),
        .req_dpl(req_dpl), .req_p(req_p), .req_cpl(req_cpl),
        .req_mode64(req_mode64), .gdt_lim(gdt_lim), .ldt_lim(ldt_lim),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
        .rsp_fault(rsp_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected fault from the requirements.
    function automatic logic [2:0] ref_fault();
        int rpl, cpl, dpl, epl, idx, endo, lim, tgt;
        logic ok;
        rpl = int'(req_sel[1:0]);
        cpl = int'(req_cpl);
        dpl = int'(req_dpl);
        tgt = int'(req_tgt);
        epl = (cpl > rpl) ? cpl : rpl;
        idx = int'(req_sel[15:3]);
        if (idx == 0 && !req_sel[2]) begin                 // R2
            ok = (tgt >= 2 && tgt <= 6) || (tgt == 1 && req_mode64 && cpl != 3);
            return ok ? 3'd0 : 3'd1;
        end
        endo = idx * 8 + ((req_mode64 && tgt >= 6) ? 15 : 7); // R3
        lim  = req_sel[2] ? int'(ldt_lim) : int'(gdt_lim);
        if (endo > lim) return 3'd2;
        case (tgt)                                          // R4 R5 R6 R7
            0: ok = req_s && req_type[3];
            1: ok = req_s && !req_type[3] && req_type[1];
            6: ok = !req_s && req_type == 4'h2;
            7: ok = !req_s && (req_type == 4'h9 || (!req_mode64 && req_type == 4'h1));
            default: ok = req_s && !(req_type[3] && !req_type[1]);
        endcase
        if (!ok) return 3'd3;
        case (tgt)                                          // R8 R9 R10
            0: ok = req_type[2] ? (cpl >= dpl) : (cpl == dpl && rpl <= cpl);
            1: ok = (rpl == cpl) && (dpl == cpl);
            6, 7: ok = 1'b1;
            default: ok = (req_type[3] && req_type[2]) ? 1'b1 : (epl <= dpl);
        endcase
        if (!ok) return 3'd4;
        if (!req_p) return (tgt == 1) ? 3'd6 : 3'd5;        // R11
        return 3'd0;
    endfunction

    function automatic string tag_of(input logic [2:0] e, input logic [2:0] t);
        case (e)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return (t == 0) ? "R4" : (t == 1) ? "R5" : (t >= 6) ? "R7" : "R6";
            3'd4: return (t == 0) ? "R10" : (t == 1) ? "R9" : "R8";
            3'd5, 3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string tag, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_pending();
        n_vec++;
        if (rsp_valid !== 1'b1 || rsp_fault !== exp_q || rsp_ok !== (exp_q == 3'd0)) begin
            n_bad++;
            $display("FAIL %s tgt=%0d actual v=%0b f=%0d ok=%0b expected v=1 f=%0d ok=%0b",
                     tag_of(exp_q, exp_tgt_q), exp_tgt_q, rsp_valid, rsp_fault, rsp_ok,
                     exp_q, exp_q == 3'd0);
        end
    endtask

    // One vector per cycle: check the previous verdict, then present the staged one.
    task automatic step(input logic [2:0] t, input logic [15:0] sl, input logic s,
                        input logic [3:0] ty, input logic [1:0] d, input logic p,
                        input logic [1:0] c, input logic m);
        @(negedge clk);
        if (pend) check_pending();
        req_tgt = t; req_sel = sl; req_s = s; req_type = ty;
        req_dpl = d; req_p = p; req_cpl = c; req_mode64 = m;
        req_valid = 1'b1;
        exp_q = ref_fault();
        exp_tgt_q = t;
        pend = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) check_pending();
        pend = 1'b0;
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_bit(rsp_valid, 1'b0, "R1", "reset rsp_valid");
        check_bit(req_ready, 1'b1, "R1", "reset req_ready");
        rst_n = 1'b1;

        // Full attribute sweep on an in-range global selector (index 5).
        for (int t = 0; t < 8; t++)
            for (int m = 0; m < 2; m++)
                for (int s = 0; s < 2; s++)
                    for (int ty = 0; ty < 16; ty++)
                        for (int d = 0; d < 4; d++)
                            for (int p = 0; p < 2; p++)
                                for (int c = 0; c < 4; c++)
                                    for (int r = 0; r < 4; r++)
                                        step(3'(t), {13'd5, 1'b0, 2'(r)}, 1'(s), 4'(ty),
                                             2'(d), 1'(p), 2'(c), 1'(m));
        flush();

        // R3 limit sweep around both table bounds.
        @(negedge clk);
        gdt_lim = 16'h00A7;
        ldt_lim = 16'h004F;
        for (int i = 0; i < 41; i++)
            for (int ti = 0; ti < 2; ti++)
                for (int t = 0; t < 8; t++)
                    for (int m = 0; m < 2; m++)
                        step(3'(t), {13'(i), 1'(ti), 2'd0}, 1'b1, 4'hA, 2'd3, 1'b1, 2'd0, 1'(m));
        flush();

        // R2 null selectors and local index 0, every level.
        for (int r = 0; r < 4; r++)
            for (int ti = 0; ti < 2; ti++)
                for (int t = 0; t < 8; t++)
                    for (int c = 0; c < 4; c++)
                        for (int m = 0; m < 2; m++)
                            step(3'(t), {13'd0, 1'(ti), 2'(r)}, 1'b0, 4'h0, 2'd0, 1'b0, 2'(c), 1'(m));
        flush();

        // R1 stall: verdict held, new requests refused.
        @(negedge clk);
        gdt_lim = 16'h00FF;
        rsp_ready = 1'b0;
        req_tgt = 3'd2; req_sel = {13'd5, 3'b000}; req_s = 1'b1; req_type = 4'h2;
        req_dpl = 2'd3; req_p = 1'b1; req_cpl = 2'd0; req_mode64 = 1'b0;
        req_valid = 1'b1;
        held = ref_fault();
        @(negedge clk);
        req_tgt = 3'd0;  // would give a type fault
        for (int k = 0; k < 3; k++) begin
            check_bit(rsp_valid, 1'b1, "R1", "stall rsp_valid");
            check_bit(req_ready, 1'b0, "R1", "stall req_ready");
            check_bit(rsp_fault == held, 1'b1, "R1", "stall verdict held");
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        held = ref_fault();
        @(negedge clk);
        check_bit(rsp_fault == held && held == 3'd3, 1'b1, "R4", "post-stall type fault");
        req_valid = 1'b0;
        @(negedge clk);
        check_bit(rsp_valid, 1'b0, "R1", "idle drops rsp_valid");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule